// File: doc/BRIEF.md
# Half-cycle pin-sharing bus link

This block carries a wide synchronous bus word (data, address, a six-bit tag and two handshake flags) across a board connection that has only about half as many pins as the word has bits. Each shared pin carries two bits per clock cycle. One bit of the pair rides on the pin while the clock is high and the other while it is low. The transmit half launches the word from registers on the rising edge and steers each pin with the clock level. The receive half takes the pins from the far side and rebuilds the word. A level-sensitive latch stores the high-phase bits and closes on the falling edge. The low-phase bits go through as plain wires. The rebuilt word is valid during the low phase of the cycle after launch, so the far side's rising-edge registers take it exactly one cycle after the sender took it.

Both halves live in one module. The transmit pins are outputs and the receive pins are separate inputs, so one instance can face either side of the link, and a bench can wire the two together. The data and address widths set the pairing: bit n of each field shares a pin with bit n plus half that field's width. A small group of handshake wires has its own pins. These wires are passed straight through, with no register and no latch, so their latency stays low.

Top module: `phase_pin_link`

## Requirements
- R1: While `rst_n` is low, `link_out` and every receive output except `rx_solo` read zero, whatever the transmit inputs are.
- R2: While `clk` is high after rising edge k, `link_out` carries the high-phase fields of the word present at edge k. Pin i < DATA_W/2 carries data bit i. The next ADDR_W/2 pins carry address bits 0 and up. The next two pins carry tag bits 0 and 1. The next pin carries the last flag, and the top pin carries the valid flag.
- R3: While `clk` is low, the same pins carry the low-phase fields. These are data bit i+DATA_W/2, address bit i+ADDR_W/2, tag bits 2 and 3, tag bit 4 (on the last-flag pin) and tag bit 5 (on the valid-flag pin).
- R4: The receive high-phase fields follow `link_in` while `clk` is high. They keep the value seen at the falling edge for the whole low phase, even though the pins have by then moved on to the low-phase bits.
- R5: The receive low-phase fields are taken from `link_in` with no storage, so they follow the pins directly.
- R6: Each data and address bit reaches only its own output bit: a single set bit at any position comes out at that position and nowhere else.
- R7: The valid flag and tag bit 5, and likewise the last flag and tag bit 4, are recovered independently of each other, although each pair shares one pin.
- R8: The unpaired handshake wires are combinational pass-throughs, `tx_solo` to `solo_out` and `solo_in` to `rx_solo`, in either clock phase.
- R9: With `link_out` wired to `link_in`, a word presented before rising edge k is complete on the receive outputs during the low phase that follows edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; its level selects the pin phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Valid flag to send (high phase, top pin) |
| tx_last | input | 1 | Last flag to send (high phase, next-to-top pin) |
| tx_id | input | 6 | Tag to send |
| tx_addr | input | ADDR_W | Address to send |
| tx_data | input | DATA_W | Data to send |
| tx_solo | input | SOLO_W | Unpaired handshake wires to send |
| link_out | output | PIN_W | Shared pins driven toward the far side |
| solo_out | output | SOLO_W | Unpaired pins driven toward the far side |
| link_in | input | PIN_W | Shared pins received from the far side |
| solo_in | input | SOLO_W | Unpaired pins received from the far side |
| rx_valid | output | 1 | Recovered valid flag |
| rx_last | output | 1 | Recovered last flag |
| rx_id | output | 6 | Recovered tag |
| rx_addr | output | ADDR_W | Recovered address |
| rx_data | output | DATA_W | Recovered data |
| rx_solo | output | SOLO_W | Recovered unpaired wires |

## Verification
The hardest case to reach is a receive latch that opens on the wrong level, or that stays open too long. Such a fault shows only when the two bits sharing a pin differ and the outputs are sampled late in the low phase. A loop-back bench driven only at the ports sees no difference when the two halves agree. The stimulus therefore sends words whose high and low halves differ, including complementary halves and one-hot values. It checks the pins in both phases of every cycle and the receive fields both just after the rising edge and just before the next one. Separate words set only one of valid/tag-5 or last/tag-4, so each shared handshake pin is shown to keep its two meanings apart.

// File: rtl/phase_pin_link.sv
`timescale 1ns/1ps
module phase_pin_link #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int SOLO_W = 4,
  localparam int DH = DATA_W / 2,
  localparam int AH = ADDR_W / 2,
  localparam int PIN_W = DH + AH + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic              tx_last,
  input  logic [5:0]        tx_id,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [SOLO_W-1:0] tx_solo,
  output logic [PIN_W-1:0]  link_out,
  output logic [SOLO_W-1:0] solo_out,
  input  logic [PIN_W-1:0]  link_in,
  input  logic [SOLO_W-1:0] solo_in,
  output logic              rx_valid,
  output logic              rx_last,
  output logic [5:0]        rx_id,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic [SOLO_W-1:0] rx_solo
);

  logic [PIN_W-1:0] hi_d, lo_d, hi_q, lo_q, hold_q;
  logic [1:0]       id_lo_a, id_lo_b;

  assign hi_d = {tx_valid, tx_last, tx_id[1:0], tx_addr[AH-1:0], tx_data[DH-1:0]};
  assign lo_d = {tx_id[5], tx_id[4], tx_id[3:2], tx_addr[ADDR_W-1:AH], tx_data[DATA_W-1:DH]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign link_out = clk ? hi_q : lo_q;
  assign solo_out = tx_solo;

  always_latch begin
    if (!rst_n)   hold_q = '0;
    else if (clk) hold_q = link_in;
  end

  assign rx_valid = hold_q[PIN_W-1];
  assign rx_last  = hold_q[PIN_W-2];
  assign id_lo_a  = hold_q[PIN_W-3:PIN_W-4];
  assign id_lo_b  = link_in[PIN_W-3:PIN_W-4];
  assign rx_id    = {link_in[PIN_W-1], link_in[PIN_W-2], id_lo_b, id_lo_a};
  assign rx_addr  = {link_in[DH+AH-1:DH], hold_q[DH+AH-1:DH]};
  assign rx_data  = {link_in[DH-1:0], hold_q[DH-1:0]};
  assign rx_solo  = solo_in;

endmodule

// File: rtl/phase_pin_link_chk.sv
`timescale 1ns/1ps
module phase_pin_link_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int SOLO_W = 4,
  localparam int DH = DATA_W / 2,
  localparam int AH = ADDR_W / 2,
  localparam int PIN_W = DH + AH + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_last,
  input logic [5:0]        tx_id,
  input logic [ADDR_W-1:0] tx_addr,
  input logic [DATA_W-1:0] tx_data,
  input logic [SOLO_W-1:0] tx_solo,
  input logic [PIN_W-1:0]  link_out,
  input logic [SOLO_W-1:0] solo_out,
  input logic [PIN_W-1:0]  link_in,
  input logic [SOLO_W-1:0] solo_in,
  input logic              rx_valid,
  input logic              rx_last,
  input logic [5:0]        rx_id,
  input logic [ADDR_W-1:0] rx_addr,
  input logic [DATA_W-1:0] rx_data,
  input logic [SOLO_W-1:0] rx_solo
);

  logic [PIN_W-1:0] want_hi, want_lo, got_hi, got_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_hi <= '0;
      want_lo <= '0;
    end else begin
      want_hi <= {tx_valid, tx_last, tx_id[1:0], tx_addr[AH-1:0], tx_data[DH-1:0]};
      want_lo <= {tx_id[5], tx_id[4], tx_id[3:2], tx_addr[ADDR_W-1:AH], tx_data[DATA_W-1:DH]};
    end
  end

  assign got_hi = {rx_valid, rx_last, rx_id[1:0], rx_addr[AH-1:0], rx_data[DH-1:0]};
  assign got_lo = {rx_id[5], rx_id[4], rx_id[3:2], rx_addr[ADDR_W-1:AH], rx_data[DATA_W-1:DH]};

  AST_HIGH_PHASE_PINS: assert property (@(negedge clk) disable iff (!rst_n) link_out == want_hi); // R2
  AST_LOW_PHASE_PINS:  assert property (@(posedge clk) disable iff (!rst_n) link_out == want_lo); // R3
  AST_LATCH_OPEN:      assert property (@(negedge clk) disable iff (!rst_n) got_hi == link_in); // R4
  AST_LOW_THROUGH:     assert property (@(posedge clk) disable iff (!rst_n) got_lo == link_in); // R5
  AST_SOLO_PASS:       assert property (@(posedge clk) disable iff (!rst_n) (rx_solo == solo_in) && (solo_out == tx_solo)); // R8

endmodule

bind phase_pin_link phase_pin_link_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SOLO_W(SOLO_W)) u_chk (.*);

// File: tb/phase_pin_link_test.sv
`timescale 1ns/1ps
module phase_pin_link_test;
  localparam int DW = 64;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int PW = DW / 2 + AW / 2 + 4;

  typedef struct packed {
    logic          v;
    logic          l;
    logic [5:0]    id;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } word_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          tx_valid = 1'b0, tx_last = 1'b0;
  logic [5:0]    tx_id = '0;
  logic [AW-1:0] tx_addr = '0;
  logic [DW-1:0] tx_data = '0;
  logic [SW-1:0] tx_solo = '0;
  logic [PW-1:0] link_out, link_in;
  logic [SW-1:0] solo_out, solo_in;
  logic          rx_valid, rx_last;
  logic [5:0]    rx_id;
  logic [AW-1:0] rx_addr;
  logic [DW-1:0] rx_data;
  logic [SW-1:0] rx_solo;

  assign link_in = link_out;
  assign solo_in = solo_out;

  phase_pin_link #(.DATA_W(DW), .ADDR_W(AW), .SOLO_W(SW)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic logic [PW-1:0] hi_pins(word_t w);
    return {w.v, w.l, w.id[1:0], w.a[AW/2-1:0], w.d[DW/2-1:0]};
  endfunction

  function automatic logic [PW-1:0] lo_pins(word_t w);
    return {w.id[5], w.id[4], w.id[3:2], w.a[AW-1:AW/2], w.d[DW-1:DW/2]};
  endfunction

  function automatic word_t got();
    return {rx_valid, rx_last, rx_id, rx_addr, rx_data};
  endfunction

  function automatic word_t rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input word_t w);
    tx_valid = w.v; tx_last = w.l; tx_id = w.id; tx_addr = w.a; tx_data = w.d;
  endtask

  task automatic step(input word_t w, input string req);
    apply(w);
    @(posedge clk); #1;
    chk({"R2 high-phase pins ", req}, link_out, hi_pins(w));
    chk({"R4 latch open ", req}, hi_pins(got()), hi_pins(w));
    #2;
    chk({"R3 low-phase pins ", req}, link_out, lo_pins(w));
    chk({"R4 latch hold ", req}, hi_pins(got()), hi_pins(w));
    chk({"R5 low-phase through ", req}, lo_pins(got()), lo_pins(w));
    chk({"R9 one-cycle word ", req}, got(), w);
  endtask

  task automatic t_reset();
    apply(rnd());
    tx_solo = 4'h5;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pins zero in reset (high)", link_out, '0);
    chk("R1 receive zero in reset (high)", got(), '0);
    #2;
    chk("R1 pins zero in reset (low)", link_out, '0);
    chk("R1 receive zero in reset (low)", got(), '0);
    chk("R8 solo live during reset", rx_solo, 4'h5);
    @(negedge clk); #0.5;
    rst_n = 1'b1;
    #0.5;
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) step(rnd(), "random");
  endtask

  task automatic t_complement();
    word_t w;
    for (int i = 0; i < 4; i++) begin
      w.d = {32'h0, 32'hFFFF_FFFF} ^ {64{i[0]}};
      w.a = {16'h0, 16'hFFFF} ^ {32{i[0]}};
      w.id = i[0] ? 6'b111100 : 6'b000011;
      w.v = ~i[0];
      w.l = ~i[0];
      step(w, "complementary halves");
    end
  endtask

  task automatic t_walk();
    word_t w;
    for (int k = 0; k < DW; k++) begin
      w = '0;
      w.d[k] = 1'b1;
      step(w, "R6 data walk");
    end
    for (int k = 0; k < AW; k++) begin
      w = '0;
      w.a[k] = 1'b1;
      step(w, "R6 addr walk");
    end
    for (int k = 0; k < 6; k++) begin
      w = '0;
      w.id[k] = 1'b1;
      step(w, "R6 tag walk");
    end
  endtask

  task automatic t_shared_flags();
    word_t w;
    for (int c = 0; c < 16; c++) begin
      w = rnd();
      w.v = c[0];
      w.id[5] = c[1];
      w.l = c[2];
      w.id[4] = c[3];
      step(w, "flags");
      chk("R7 valid vs tag5", {rx_valid, rx_id[5]}, {c[0], c[1]});
      chk("R7 last vs tag4", {rx_last, rx_id[4]}, {c[2], c[3]});
    end
  endtask

  task automatic t_solo();
    for (int i = 0; i < 6; i++) begin
      logic [SW-1:0] s;
      s = SW'($urandom);
      tx_solo = s;
      #0.5;
      chk("R8 solo out", solo_out, s);
      chk("R8 solo in", rx_solo, s);
      #1.5;
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_random();
    t_complement();
    t_walk();
    t_shared_flags();
    t_solo();
    step(rnd(), "final");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule